// File: doc/BRIEF.md
# Power-Good Qualification and Delay Generator

This block drives the power-good signal of a power-supply supervisor. It takes digital comparator results and produces one clean, registered power-good level. The comparator results are a two-threshold window on a power-good sense input, undervoltage flags for the 3.3 V and 5 V rails, and the debounced on/off command and fault-latch status from the protection controller. A free-running microsecond tick sets its time base.

Power-good turns on slowly and turns off quickly. It turns on only after every good condition has held without a break for a long qualification delay. A parameter selects the long or the short delay. It turns off within a short deglitch window when the sense input or a rail sags. It turns off on the next clock edge when a fault is latched or the supply is commanded off. The two sense thresholds give hysteresis. While power-good is low, a sense input inside the window keeps it low. While power-good is high, the same input keeps it high.

Top module: `pg_delay_gen`

## Requirements
- R1: While `rst` is high, `pwr_good` is 0 at every clock edge, and the rise-delay count is cleared. After reset is released, the full rise delay is needed before `pwr_good` can go to 1.
- R2: With `LONG_DELAY`=1, the qualify condition is `pgin_above_hi`=1, `pgin_below_lo`=0, `uv_3v3`=0, `uv_5v`=0, `supply_on`=1 and `fault_latched`=0. If it holds with a tick every cycle, `pwr_good` goes to 1 at the (`RISE_LONG_US`+1)-th clock edge after it starts, and not earlier.
- R3: With `LONG_DELAY`=0, the same rise takes `RISE_SHORT_US`+1 edges.
- R4: While `pwr_good` is 0, a sense input inside the window (`pgin_above_hi`=0, `pgin_below_lo`=0) keeps `pwr_good` at 0 for any length of time.
- R5: Any cycle in which the qualify condition is false restarts the rise delay from zero.
- R6: While `pwr_good` is 1, a sense input inside the window does not clear it.
- R7: While `pwr_good` is 1, consider `pgin_below_lo`=1, `uv_3v3`=1 or `uv_5v`=1, present without a break. `pwr_good` goes to 0 at the first edge at which this has been present for more than `FALL_US` ticks. With a tick every cycle, that is edge `FALL_US`+1.
- R8: A drop condition that lasts `FALL_US` cycles or fewer leaves `pwr_good` at 1.
- R9: `fault_latched`=1 at a clock edge makes `pwr_good` 0 after that edge. This holds even when a rise delay completes at the same edge.
- R10: `supply_on`=0 at a clock edge makes `pwr_good` 0 after that edge.
- R11: Both delays advance only on cycles with `us_tick`=1. Cycles without a tick add no delay progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| pgin_above_hi | input | 1 | Sense input above the upper threshold |
| pgin_below_lo | input | 1 | Sense input below the lower threshold |
| uv_3v3 | input | 1 | 3.3 V rail undervoltage flag |
| uv_5v | input | 1 | 5 V rail undervoltage flag |
| supply_on | input | 1 | Debounced supply-on command |
| fault_latched | input | 1 | Protection latch is set |
| pwr_good | output | 1 | Registered power-good level |

## Verification
Two events can land on the same clock edge: completion of the rise delay and a fault veto. The bench holds the qualify condition until the edge just before the rise would complete. It then raises the fault latch for exactly that edge. `pwr_good` must stay 0, and the rise must then need the full delay again. A deglitch timeout that meets a window-only input is judged the same way. The input is brought back from below the lower threshold into the window on the edge where the count is full, and `pwr_good` must stay 1.

// File: rtl/pgd_pkg.sv
package pgd_pkg;

    typedef enum logic {
        PGS_LOW  = 1'b0,
        PGS_HIGH = 1'b1
    } pg_state_e;

    // Classified view of the raw input flags.
    typedef struct packed {
        logic qualify;   // every condition needed to rise is present
        logic sag;       // a soft drop cause (sense low or rail UV)
        logic veto;      // hard cause: fault latched or supply off
    } pg_cond_t;

    function automatic int unsigned pick_rise_us(
        input bit          long_sel,
        input int unsigned long_us,
        input int unsigned short_us
    );
        return long_sel ? long_us : short_us;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/pgd_classify.sv
module pgd_classify
    import pgd_pkg::*;
(
    input  logic     above_hi,
    input  logic     below_lo,
    input  logic     uv_a,
    input  logic     uv_b,
    input  logic     on_cmd,
    input  logic     fault,
    output pg_cond_t cond
);
    logic rails_ok;
    logic sense_ok;

    always_comb begin
        rails_ok     = !uv_a && !uv_b;
        sense_ok     = above_hi && !below_lo;
        cond.veto    = fault || !on_cmd;
        cond.sag     = below_lo || !rails_ok;
        cond.qualify = sense_ok && rails_ok && !cond.veto;
    end
endmodule

// File: rtl/pgd_tick_timer.sv
module pgd_tick_timer
    import pgd_pkg::*;
#(
    parameter int unsigned LIMIT = 150
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic run,
    output logic expired
);
    localparam int unsigned W = cnt_width(LIMIT);
    localparam logic [W-1:0] LIM_V = W'(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick && cnt != LIM_V) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb expired = run && (cnt == LIM_V);
endmodule

// File: rtl/pgd_state.sv
module pgd_state
    import pgd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pg_cond_t cond,
    input  logic     rise_done,
    input  logic     fall_done,
    output logic     pg_q
);
    pg_state_e st, st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            PGS_LOW: begin
                if (rise_done && cond.qualify) st_nx = PGS_HIGH;
            end
            PGS_HIGH: begin
                if (cond.veto)                   st_nx = PGS_LOW;
                else if (fall_done && cond.sag)  st_nx = PGS_LOW;
            end
            default: st_nx = PGS_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= PGS_LOW;
        else     st <= st_nx;
    end

    always_comb pg_q = (st == PGS_HIGH);
endmodule

// File: rtl/pg_delay_gen.sv
module pg_delay_gen
    import pgd_pkg::*;
#(
    parameter bit          LONG_DELAY    = 1'b1,
    parameter int unsigned RISE_LONG_US  = 300000,
    parameter int unsigned RISE_SHORT_US = 150000,
    parameter int unsigned FALL_US       = 150
) (
    input  logic clk,
    input  logic rst,
    input  logic us_tick,
    input  logic pgin_above_hi,
    input  logic pgin_below_lo,
    input  logic uv_3v3,
    input  logic uv_5v,
    input  logic supply_on,
    input  logic fault_latched,
    output logic pwr_good
);
    localparam int unsigned RISE_US = pick_rise_us(LONG_DELAY, RISE_LONG_US, RISE_SHORT_US);

    pg_cond_t cond;
    logic     pg_q;
    logic     rise_run, fall_run;
    logic     rise_done, fall_done;

    pgd_classify u_cls (
        .above_hi (pgin_above_hi),
        .below_lo (pgin_below_lo),
        .uv_a     (uv_3v3),
        .uv_b     (uv_5v),
        .on_cmd   (supply_on),
        .fault    (fault_latched),
        .cond     (cond)
    );

    always_comb begin
        rise_run = cond.qualify && !pg_q;
        fall_run = cond.sag && pg_q;
    end

    pgd_tick_timer #(.LIMIT(RISE_US)) u_rise (
        .clk     (clk),
        .rst     (rst),
        .tick    (us_tick),
        .run     (rise_run),
        .expired (rise_done)
    );

    pgd_tick_timer #(.LIMIT(FALL_US)) u_fall (
        .clk     (clk),
        .rst     (rst),
        .tick    (us_tick),
        .run     (fall_run),
        .expired (fall_done)
    );

    pgd_state u_st (
        .clk       (clk),
        .rst       (rst),
        .cond      (cond),
        .rise_done (rise_done),
        .fall_done (fall_done),
        .pg_q      (pg_q)
    );

    always_comb pwr_good = pg_q;
endmodule

// File: rtl/pgd_chk.sv
module pgd_chk (
    input logic clk,
    input logic rst,
    input logic pgin_above_hi,
    input logic pgin_below_lo,
    input logic uv_3v3,
    input logic uv_5v,
    input logic supply_on,
    input logic fault_latched,
    input logic pwr_good
);
    // R1
    reset_low_chk: assert property (@(posedge clk) rst |=> !pwr_good);

    // R9
    fault_veto_chk: assert property (@(posedge clk) disable iff (rst)
        fault_latched |=> !pwr_good);

    // R10
    off_veto_chk: assert property (@(posedge clk) disable iff (rst)
        !supply_on |=> !pwr_good);

    // R4
    rise_qual_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_good && !(pgin_above_hi && !pgin_below_lo) |=> !pwr_good);

    // R6
    window_hold_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_good && !pgin_below_lo && !uv_3v3 && !uv_5v && supply_on && !fault_latched
        |=> pwr_good);
endmodule

bind pg_delay_gen pgd_chk u_pgd_chk (
    .clk           (clk),
    .rst           (rst),
    .pgin_above_hi (pgin_above_hi),
    .pgin_below_lo (pgin_below_lo),
    .uv_3v3        (uv_3v3),
    .uv_5v         (uv_5v),
    .supply_on     (supply_on),
    .fault_latched (fault_latched),
    .pwr_good      (pwr_good)
);

// File: tb/tb_pg_delay_gen.sv
`timescale 1ns/1ps
module tb_pg_delay_gen;
    localparam int unsigned RL = 40;
    localparam int unsigned RS = 20;
    localparam int unsigned FL = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic us_tick = 1'b1;
    logic above = 1'b0, below = 1'b0, uva = 1'b0, uvb = 1'b0, on = 1'b0, flt = 1'b0;
    logic pg, pg_s;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    pg_delay_gen #(.LONG_DELAY(1'b1), .RISE_LONG_US(RL), .RISE_SHORT_US(RS), .FALL_US(FL)) dut (
        .clk(clk), .rst(rst), .us_tick(us_tick),
        .pgin_above_hi(above), .pgin_below_lo(below), .uv_3v3(uva), .uv_5v(uvb),
        .supply_on(on), .fault_latched(flt), .pwr_good(pg)
    );

    pg_delay_gen #(.LONG_DELAY(1'b0), .RISE_LONG_US(RL), .RISE_SHORT_US(RS), .FALL_US(FL)) dut_s (
        .clk(clk), .rst(rst), .us_tick(us_tick),
        .pgin_above_hi(above), .pgin_below_lo(below), .uv_3v3(uva), .uv_5v(uvb),
        .supply_on(on), .fault_latched(flt), .pwr_good(pg_s)
    );

    // input bits: [5] above_hi [4] below_lo [3] uv_3v3 [2] uv_5v [1] on [0] fault
    localparam logic [5:0] GOOD = 6'b100010;
    localparam logic [5:0] WIN  = 6'b000010;
    localparam logic [5:0] LOWS = 6'b010010;
    localparam logic [5:0] UVA  = 6'b101010;
    localparam logic [5:0] UVB  = 6'b100110;
    localparam logic [5:0] FLT  = 6'b100011;
    localparam logic [5:0] OFF  = 6'b100000;

    // entry: {inputs[18:13], hold edges[12:5], expected pg[4], requirement number[3:0]}
    localparam int NV = 17;
    localparam logic [18:0] VEC [NV] = '{
        {GOOD, 8'd40,  1'b0, 4'd2},   // R2 not yet
        {GOOD, 8'd1,   1'b1, 4'd2},   // R2 rises
        {WIN,  8'd20,  1'b1, 4'd6},   // R6 hysteresis
        {LOWS, 8'd6,   1'b1, 4'd8},   // R8 short sag
        {GOOD, 8'd1,   1'b1, 4'd8},   // R8 removed on full count
        {UVA,  8'd7,   1'b0, 4'd7},   // R7 3.3 V undervoltage
        {GOOD, 8'd20,  1'b0, 4'd5},   // R5 partial qualify
        {WIN,  8'd1,   1'b0, 4'd5},   // R5 break
        {GOOD, 8'd40,  1'b0, 4'd5},   // R5 restarted from zero
        {GOOD, 8'd1,   1'b1, 4'd5},   // R5 completes
        {UVB,  8'd7,   1'b0, 4'd7},   // R7 5 V undervoltage
        {WIN,  8'd100, 1'b0, 4'd4},   // R4 window keeps low
        {GOOD, 8'd41,  1'b1, 4'd2},   // R2
        {FLT,  8'd1,   1'b0, 4'd9},   // R9 fault
        {GOOD, 8'd41,  1'b1, 4'd9},   // R9 recovery
        {OFF,  8'd1,   1'b0, 4'd10},  // R10 off
        {GOOD, 8'd41,  1'b1, 4'd10}   // R10 recovery
    };

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: pwr_good=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic [5:0] v);
        {above, below, uva, uvb, on, flt} = v;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        drive(GOOD);
        edges(3);
        check("R1 reset", pg, 1'b0);
        check("R1 reset short", pg_s, 1'b0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : wd
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        drive(GOOD);
        rst = 1'b1;
        edges(4);
        check("R1 reset", pg, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][18:13]);
            edges(int'(VEC[i][12:5]));
            check($sformatf("R%0d vec%0d", VEC[i][3:0], i), pg, VEC[i][4]);
            @(negedge clk);
        end

        // R1: reset while high clears power-good and the rise count
        do_reset();
        drive(GOOD);
        edges(int'(RL));
        check("R1 full delay after reset", pg, 1'b0);
        edges(1);
        check("R1 rise after reset", pg, 1'b1);

        // R3: short variant rises after RS+1 edges, long one still low
        do_reset();
        drive(GOOD);
        edges(int'(RS));
        check("R3 short not yet", pg_s, 1'b0);
        edges(1);
        check("R3 short rises", pg_s, 1'b1);
        check("R2 long still low", pg, 1'b0);

        // R11: no ticks means no progress
        do_reset();
        us_tick = 1'b0;
        drive(GOOD);
        edges(100);
        check("R11 no tick stays low", pg, 1'b0);
        @(negedge clk);
        us_tick = 1'b1;
        edges(int'(RL));
        check("R11 counts only ticks", pg, 1'b0);
        edges(1);
        check("R11 rise after ticks", pg, 1'b1);

        // R7 with gated ticks: drop needs FL+1 tick-edges
        @(negedge clk);
        drive(LOWS);
        us_tick = 1'b0;
        edges(30);
        check("R11 sag without ticks", pg, 1'b1);
        @(negedge clk);
        us_tick = 1'b1;
        edges(int'(FL) + 1);
        check("R7 sag below lower threshold", pg, 1'b0);

        // R9: fault on the edge where the rise delay completes
        do_reset();
        drive(GOOD);
        edges(int'(RL));
        @(negedge clk);
        drive(FLT);
        edges(1);
        check("R9 fault at rise edge", pg, 1'b0);
        @(negedge clk);
        drive(GOOD);
        edges(int'(RL));
        check("R5 restart after veto", pg, 1'b0);
        edges(1);
        check("R5 rise after veto", pg, 1'b1);

        // R6/R8: sag count full, then input moves into the window
        @(negedge clk);
        drive(LOWS);
        edges(int'(FL));
        @(negedge clk);
        drive(WIN);
        edges(5);
        check("R8 sag to window stays high", pg, 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule